// File: doc/BRIEF.md
# Ternary Match Table With Priority Search

This block is a small ternary lookup table. Each row holds a stored word and a care mask of the same width. A search applies a key to every row in one cycle. A row counts as a hit when it satisfies three conditions:

- it has been written since reset;
- it is not marked as already visited;
- it agrees with the key on every bit that both its own care mask and the shared search mask select.

The result is registered. It reports whether anything hit, whether more than one row hit, and which hit has the smallest index.

A controller that needs every match walks the hits one at a time. It searches, marks the reported row as visited, and searches again. It repeats this while the multiple-hit flag stays high, then clears all marks with a single command. The shared search mask lets one stored word hold several key fields, with a search restricted to just one of them. Reads return a row's stored word and care mask. Every command is acknowledged one cycle after it is issued.

Top module: `tcam_engine`

## Requirements
- R1: A written, unmarked row hits when `((row_data ^ key) & row_mask & search_mask) == 0`. A care bit of 0 makes that bit position always agree with the key.
- R2: When several rows hit, `rsp_addr` reports the smallest row index among them.
- R3: `rsp_multi` is 1 after a search in which two or more rows hit, and 0 otherwise.
- R4: The shared search mask resets to all ones. Opcode 4 loads it from `cmd_mask`. Bit positions where it is 0 are ignored by every row during searches.
- R5: `rsp_hit` is 1 after a search with at least one hit. After a search with no hit, `rsp_hit`, `rsp_multi` and `rsp_addr` are all 0.
- R6: Opcode 1 (read) returns the stored word on `rsp_rdata` and the care mask on `rsp_rmask` for row `cmd_addr`, one cycle after the command.
- R7: Opcode 2 (write) stores `cmd_data` and `cmd_mask` into row `cmd_addr` and makes that row valid. Every command with `cmd_valid` high, and no other cycle, is followed one cycle later by `rsp_ack` = 1. Opcode 0 does nothing except acknowledge.
- R8: A row not written since reset never hits.
- R9: Opcode 5 marks row `cmd_addr` as visited and opcode 6 unmarks it. A marked row never hits.
- R10: Opcode 7 unmarks every row in one command, so that the next search sees all rows as unmarked.
- R11: Opcode 3 (search) updates `rsp_hit`, `rsp_multi` and `rsp_addr` one cycle after the command. These outputs hold their values through every cycle that is not a search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode: 0 nop, 1 read, 2 write, 3 search, 4 load search mask, 5 mark, 6 unmark, 7 unmark all |
| cmd_addr | input | AW (4) | Row index for read, write, mark and unmark |
| cmd_data | input | WIDTH (72) | Word to store on write |
| cmd_mask | input | WIDTH (72) | Care mask on write; new search mask on opcode 4 |
| cmd_key | input | WIDTH (72) | Search key |
| rsp_ack | output | 1 | Command completed (one cycle after issue) |
| rsp_hit | output | 1 | Last search found at least one row |
| rsp_multi | output | 1 | Last search found two or more rows |
| rsp_addr | output | AW (4) | Smallest hitting row index of the last search, 0 on a miss |
| rsp_rdata | output | WIDTH (72) | Stored word from the last read |
| rsp_rmask | output | WIDTH (72) | Care mask from the last read |

## Verification
Two kinds of result share the response side: the search result registers and the read return registers. A read must refresh its data without disturbing the held search outcome. A mark or search-mask change must also take effect on a search issued right behind it.

The bench provokes these cases in two ways:

- Directed sequences issue a search, then a read, then mark, unmark and mask commands, each immediately followed by a search.
- A random command mix of several hundred commands interleaves all opcodes over rows with shared low-order keys, so that multiple hits are common.

The bench judges each response against a table model kept in the bench. The search outputs are compared after every command, including the non-search ones, where they must still equal the last search's values.

// File: rtl/tcam_engine.sv
module tcam_engine #(
  parameter int ROWS  = 16,
  parameter int WIDTH = 72,
  localparam int AW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [WIDTH-1:0] cmd_data,
  input  logic [WIDTH-1:0] cmd_mask,
  input  logic [WIDTH-1:0] cmd_key,
  output logic             rsp_ack,
  output logic             rsp_hit,
  output logic             rsp_multi,
  output logic [AW-1:0]    rsp_addr,
  output logic [WIDTH-1:0] rsp_rdata,
  output logic [WIDTH-1:0] rsp_rmask
);
  localparam logic [2:0] OP_READ   = 3'd1;
  localparam logic [2:0] OP_WRITE  = 3'd2;
  localparam logic [2:0] OP_SEARCH = 3'd3;
  localparam logic [2:0] OP_GMASK  = 3'd4;
  localparam logic [2:0] OP_MARK   = 3'd5;
  localparam logic [2:0] OP_UNMARK = 3'd6;
  localparam logic [2:0] OP_CLRALL = 3'd7;

  logic [WIDTH-1:0] data_q [ROWS];
  logic [WIDTH-1:0] mask_q [ROWS];
  logic [ROWS-1:0]  valid_q, tag_q, hit_vec;
  logic [WIDTH-1:0] gmask_q;
  logic [AW-1:0]    win;

  wire in_range = (32'(cmd_addr) < ROWS);
  wire do_op    = cmd_valid & in_range;

  for (genvar r = 0; r < ROWS; r++) begin : g_cmp
    assign hit_vec[r] = valid_q[r] & ~tag_q[r] &
                        ~|((data_q[r] ^ cmd_key) & mask_q[r] & gmask_q);
  end

  always_comb begin
    win = '0;
    for (int r = ROWS - 1; r >= 0; r--)
      if (hit_vec[r]) win = AW'(r);
  end

  wire multi = |(hit_vec & (hit_vec - {{(ROWS-1){1'b0}}, 1'b1}));

  always_ff @(posedge clk)
    if (do_op && cmd_op == OP_WRITE) begin
      data_q[cmd_addr] <= cmd_data;
      mask_q[cmd_addr] <= cmd_mask;
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= '0;
      tag_q     <= '0;
      gmask_q   <= '1;
      rsp_ack   <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_addr  <= '0;
      rsp_rdata <= '0;
      rsp_rmask <= '0;
    end else begin
      rsp_ack <= cmd_valid;
      if (cmd_valid) begin
        case (cmd_op)
          OP_READ: if (in_range) begin
            rsp_rdata <= data_q[cmd_addr];
            rsp_rmask <= mask_q[cmd_addr];
          end
          OP_WRITE:  if (in_range) valid_q[cmd_addr] <= 1'b1;
          OP_SEARCH: begin
            rsp_hit   <= |hit_vec;
            rsp_multi <= multi;
            rsp_addr  <= win;
          end
          OP_GMASK:  gmask_q <= cmd_mask;
          OP_MARK:   if (in_range) tag_q[cmd_addr] <= 1'b1;
          OP_UNMARK: if (in_range) tag_q[cmd_addr] <= 1'b0;
          OP_CLRALL: tag_q <= '0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tcam_engine_chk.sv
module tcam_engine_chk #(
  parameter int ROWS = 16,
  localparam int AW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [2:0]      cmd_op,
  input logic            rsp_ack,
  input logic            rsp_hit,
  input logic            rsp_multi,
  input logic [AW-1:0]   rsp_addr,
  input logic [ROWS-1:0] tag_q,
  input logic [ROWS-1:0] valid_q
);
  logic [ROWS-1:0] tag_d, valid_d;
  always_ff @(posedge clk)
    if (!rst_n) begin
      tag_d   <= '0;
      valid_d <= '0;
    end else begin
      tag_d   <= tag_q;
      valid_d <= valid_q;
    end

  wire srch = cmd_valid && cmd_op == 3'd3;

  assert_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_ack);
  assert_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_ack);
  assert_multi_has_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> rsp_hit);
  assert_miss_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_addr == '0);
  assert_hold_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !srch |=> $stable(rsp_hit) && $stable(rsp_multi) && $stable(rsp_addr));
  assert_marked_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srch |=> !(rsp_hit && tag_d[rsp_addr]));
  assert_invalid_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srch |=> !(rsp_hit && !valid_d[rsp_addr]));
  assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd7) |=> tag_q == '0);
endmodule

bind tcam_engine tcam_engine_chk #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rsp_ack(rsp_ack), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi),
  .rsp_addr(rsp_addr), .tag_q(tag_q), .valid_q(valid_q)
);

// File: tb/test_tcam_engine.sv
module test_tcam_engine;
  localparam int ROWS = 16;
  localparam int WIDTH = 72;
  localparam int AW = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [WIDTH-1:0] cmd_data = 0, cmd_mask = 0, cmd_key = 0;
  logic rsp_ack, rsp_hit, rsp_multi;
  logic [AW-1:0] rsp_addr;
  logic [WIDTH-1:0] rsp_rdata, rsp_rmask;

  tcam_engine #(.ROWS(ROWS), .WIDTH(WIDTH)) i_tcam_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_mask(cmd_mask),
    .cmd_key(cmd_key), .rsp_ack(rsp_ack), .rsp_hit(rsp_hit),
    .rsp_multi(rsp_multi), .rsp_addr(rsp_addr), .rsp_rdata(rsp_rdata),
    .rsp_rmask(rsp_rmask));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [WIDTH-1:0] m_data [ROWS];
  logic [WIDTH-1:0] m_mask [ROWS];
  logic [ROWS-1:0] m_valid = '0, m_tag = '0;
  logic [WIDTH-1:0] m_gmask = '1;
  logic e_hit = 0, e_multi = 0;
  logic [AW-1:0] e_addr = 0;
  logic [WIDTH-1:0] e_rdata = 0, e_rmask = 0;

  task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_search(input logic [WIDTH-1:0] k, output logic h, output logic mu,
                              output logic [AW-1:0] ad);
    int cnt = 0;
    ad = '0;
    for (int r = ROWS - 1; r >= 0; r--)
      if (m_valid[r] && !m_tag[r] && (((m_data[r] ^ k) & m_mask[r] & m_gmask) == '0)) begin
        cnt++;
        ad = AW'(r);
      end
    h = (cnt > 0);
    mu = (cnt > 1);
  endtask

  task automatic run(input logic [2:0] op, input int a, input logic [WIDTH-1:0] d,
                     input logic [WIDTH-1:0] m, input logic [WIDTH-1:0] k, input string req);
    case (op)
      3'd1: if (m_valid[a]) begin e_rdata = m_data[a]; e_rmask = m_mask[a]; end
      3'd2: begin m_data[a] = d; m_mask[a] = m; m_valid[a] = 1'b1; end
      3'd3: model_search(k, e_hit, e_multi, e_addr);
      3'd4: m_gmask = m;
      3'd5: m_tag[a] = 1'b1;
      3'd6: m_tag[a] = 1'b0;
      3'd7: m_tag = '0;
      default: ;
    endcase
    cmd_valid = 1; cmd_op = op; cmd_addr = AW'(a);
    cmd_data = d; cmd_mask = m; cmd_key = k;
    @(negedge clk);
    cmd_valid = 0;
    check({req, " ack R7"}, WIDTH'(rsp_ack), WIDTH'(1'b1));
    check({req, " hit R5/R11"}, WIDTH'(rsp_hit), WIDTH'(e_hit));
    check({req, " multi R3/R11"}, WIDTH'(rsp_multi), WIDTH'(e_multi));
    check({req, " addr R2/R11"}, WIDTH'(rsp_addr), WIDTH'(e_addr));
    if (op == 3'd1 && m_valid[a]) begin
      check({req, " rdata R6"}, rsp_rdata, e_rdata);
      check({req, " rmask R6"}, rsp_rmask, e_rmask);
    end
  endtask

  function automatic logic [WIDTH-1:0] rnd72();
    return {$urandom(), $urandom(), 8'($urandom())};
  endfunction

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] a72, k;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check("reset ack R7", WIDTH'(rsp_ack), '0);
    check("reset hit R5", WIDTH'(rsp_hit), '0);
    check("reset addr R5", WIDTH'(rsp_addr), '0);
    @(negedge clk);
    check("idle no ack R7", WIDTH'(rsp_ack), '0);

    run(3'd3, 0, '0, '0, '0, "empty search R8");
    run(3'd0, 0, '0, '0, '0, "nop R7");
    a72 = 72'hA5_1234_5678_9ABC_DEF0;
    run(3'd2, 9, a72, '1, '0, "write r9 R7");
    run(3'd2, 3, a72, '1, '0, "write r3 R7");
    run(3'd3, 0, '0, '0, a72, "two hits lowest R2 R3");
    run(3'd1, 9, '0, '0, '0, "read r9 R6");
    check("search held across read R11", WIDTH'({rsp_hit, rsp_multi, rsp_addr}), WIDTH'(6'b11_0011));
    run(3'd5, 3, '0, '0, '0, "mark r3 R9");
    run(3'd3, 0, '0, '0, a72, "marked skipped R9");
    check("after mark addr R9", WIDTH'(rsp_addr), WIDTH'(9));
    run(3'd5, 9, '0, '0, '0, "mark r9 R9");
    run(3'd3, 0, '0, '0, a72, "all marked miss R9 R5");
    run(3'd6, 9, '0, '0, '0, "unmark r9 R9");
    run(3'd3, 0, '0, '0, a72, "unmarked hit R9");
    run(3'd5, 9, '0, '0, '0, "mark r9 again R9");
    run(3'd7, 0, '0, '0, '0, "unmark all R10");
    run(3'd3, 0, '0, '0, a72, "after clear all R10");
    check("after clear all multi R10", WIDTH'(rsp_multi), WIDTH'(1'b1));
    run(3'd3, 0, '0, '0, a72 ^ 72'h1, "bit0 differs miss R1");
    run(3'd4, 0, '0, ~72'h1, '0, "search mask drop bit0 R4");
    run(3'd3, 0, '0, '0, a72 ^ 72'h1, "search mask ignore R4");
    check("search mask hit R4", WIDTH'(rsp_hit), WIDTH'(1'b1));
    run(3'd4, 0, '0, '1, '0, "restore search mask R4");
    run(3'd2, 12, 72'h55, 72'hFF, '0, "write ternary r12 R1");
    run(3'd3, 0, '0, '0, {64'hDEAD_BEEF_0BAD_F00D, 8'h55}, "ternary dont care R1");
    check("ternary addr R1", WIDTH'(rsp_addr), WIDTH'(12));
    run(3'd3, 0, '0, '0, {64'hDEAD_BEEF_0BAD_F00D, 8'h54}, "ternary care bit R1");

    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 99);
      int a = $urandom_range(0, ROWS - 1);
      logic [WIDTH-1:0] d, m;
      d = rnd72();
      case ($urandom_range(0, 2))
        0: m = '1;
        1: m = 72'hFF;
        default: m = rnd72();
      endcase
      d[7:0] = 8'($urandom_range(0, 3));
      if (sel < 30) run(3'd2, a, d, m, '0, "rand write R7");
      else if (sel < 70) begin
        int b = $urandom_range(0, ROWS - 1);
        if (m_valid[b] && $urandom_range(0, 9) < 7)
          k = m_data[b] ^ (rnd72() & ~(m_mask[b] & m_gmask));
        else begin
          k = rnd72(); k[7:0] = 8'($urandom_range(0, 3));
        end
        run(3'd3, 0, '0, '0, k, "rand search R1 R2 R3");
      end
      else if (sel < 80) run(3'd1, a, '0, '0, '0, "rand read R6");
      else if (sel < 86) run(3'd5, a, '0, '0, '0, "rand mark R9");
      else if (sel < 91) run(3'd6, a, '0, '0, '0, "rand unmark R9");
      else if (sel < 94) run(3'd7, 0, '0, '0, '0, "rand clear all R10");
      else run(3'd4, 0, '0, ($urandom_range(0, 1) != 0) ? '1 : ~rnd72(), '0, "rand search mask R4");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule